// File: doc/BRIEF.md
# Triple-Buffer Sequence Index Manager

This block decides which of three buffer slots a producer of PWM edge data may fill next, and what a playback sequencer should play each time it finishes a sequence. Every slot carries two sequences: a one-shot update sequence and a repeating loop sequence. The block stores only slot indices and ownership flags. The sequence contents live elsewhere.

The producer first asks for a slot by pulsing a begin strobe. It receives a slot index that is neither the slot being played nor the slot it last committed. It fills both sequences of that slot and then pulses commit. The consumer pulses an end-of-sequence strobe. The block answers one cycle later with the slot to play and whether to play its update or its loop sequence. It also reports which buffer is handed back to the list it came from.

A picked-up flag tells the producer whether the consumer has already moved onto the most recent commit.

Top module: `seqbuf_index_mgr`

## Requirements
- R1: After reset, the read index and the last-written index are both 0. `picked_up` is 1, `wr_busy` is 0, and `play_valid` and `rel_valid` are 0.
- R2: A `wr_begin` pulse while `wr_busy` is 0 does two things from the next cycle: it sets `wr_busy`, and it presents on `wr_slot` the index (read+1) mod 3. If that index equals the last-written index, `wr_slot` shows (read+2) mod 3 instead. The granted slot never equals the read index.
- R3: While `wr_busy` is 1, `wr_slot` stays constant and further `wr_begin` pulses are ignored.
- R4: A `wr_commit` pulse while `wr_busy` is 1 does two things from the next cycle: it makes `wr_slot` the last-written index, and it clears `wr_busy`. A `wr_commit` while `wr_busy` is 0 has no effect.
- R5: `picked_up` is 1 exactly when the read index equals the last-written index.
- R6: On `seq_end` with the last-written index different from the read index, the read index takes the last-written index. One cycle later, `play_valid` pulses with `play_slot` equal to that index and `play_loop` equal to 0, meaning the update sequence.
- R7: On `seq_end` with the two indices equal, one cycle later `play_valid` pulses with `play_slot` equal to the read index and `play_loop` equal to 1, meaning the loop sequence.
- R8: With every `play_valid` pulse after the first since reset, `rel_valid` pulses and `rel_slot`/`rel_loop` name the buffer that was playing before. With the first pulse, `rel_valid` stays 0.
- R9: When `wr_commit` and `seq_end` fall in the same cycle, the playback choice uses the indices from before the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_begin | input | 1 | Producer requests a slot to fill |
| wr_commit | input | 1 | Producer has finished filling both sequences of its slot |
| wr_slot | output | 2 | Slot granted to the producer |
| wr_busy | output | 1 | A slot is granted and not yet committed |
| picked_up | output | 1 | Consumer has reached the last committed slot |
| seq_end | input | 1 | Consumer finished the current sequence |
| play_valid | output | 1 | One-cycle pulse: a new playback choice is presented |
| play_slot | output | 2 | Slot to play |
| play_loop | output | 1 | 1 = loop sequence, 0 = update sequence |
| rel_valid | output | 1 | One-cycle pulse: a buffer is handed back |
| rel_slot | output | 2 | Slot of the returned buffer |
| rel_loop | output | 1 | 1 = returned buffer belongs to the loop list |

## Verification
The bench builds the block with its default of three slots, the only legal value, so every index pair the read and last-written registers can hold is reachable. The stimulus covers the case where the producer commits twice before the consumer catches up, which forces the (read+2) choice. It covers repeated loop playback with no commit in between, and a commit landing in the same cycle as an end-of-sequence strobe.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;
   typedef logic [1:0] slot_t;

   localparam int unsigned SLOTS = 3;

   function automatic slot_t slot_inc(input slot_t s);
      return (s == slot_t'(SLOTS - 1)) ? slot_t'(0) : slot_t'(s + 2'd1);
   endfunction

   typedef struct packed {
      slot_t slot;
      logic  loop;
   } play_t;
endpackage

// File: rtl/seqbuf_write_picker.sv
module seqbuf_write_picker
   import seqbuf_pkg::*;
(
   input  slot_t rd_idx,
   input  slot_t lw_idx,
   output slot_t pick
);
   slot_t first_try;
   slot_t second_try;

   always_comb begin
      first_try  = slot_inc(rd_idx);
      second_try = slot_inc(first_try);
      pick       = (first_try == lw_idx) ? second_try : first_try;
   end
endmodule

// File: rtl/seqbuf_producer_port.sv
module seqbuf_producer_port
   import seqbuf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_begin,
   input  logic  wr_commit,
   input  slot_t pick,
   output slot_t grant_slot,
   output logic  busy,
   output slot_t lw_idx
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         grant_slot <= '0;
         lw_idx     <= '0;
      end else if (!busy && wr_begin) begin
         busy       <= 1'b1;
         grant_slot <= pick;
      end else if (busy && wr_commit) begin
         busy       <= 1'b0;
         lw_idx     <= grant_slot;
      end
   end
endmodule

// File: rtl/seqbuf_consumer_port.sv
module seqbuf_consumer_port
   import seqbuf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  seq_end,
   input  slot_t lw_idx,
   output slot_t rd_idx,
   output logic  play_valid,
   output play_t play_cur,
   output logic  rel_valid,
   output play_t rel_buf
);
   logic  started;
   play_t next_play;

   always_comb begin
      if (lw_idx != rd_idx) begin
         next_play.slot = lw_idx;
         next_play.loop = 1'b0;
      end else begin
         next_play.slot = rd_idx;
         next_play.loop = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx     <= '0;
         started    <= 1'b0;
         play_valid <= 1'b0;
         rel_valid  <= 1'b0;
         play_cur   <= '0;
         rel_buf    <= '0;
      end else if (seq_end) begin
         rd_idx     <= next_play.slot;
         started    <= 1'b1;
         play_valid <= 1'b1;
         rel_valid  <= started;
         rel_buf    <= play_cur;
         play_cur   <= next_play;
      end else begin
         play_valid <= 1'b0;
         rel_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/seqbuf_index_mgr.sv
module seqbuf_index_mgr
   import seqbuf_pkg::*;
#(
   parameter int unsigned SLOT_COUNT = 3,
   parameter int unsigned IDX_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_begin,
   input  logic             wr_commit,
   output logic [IDX_W-1:0] wr_slot,
   output logic             wr_busy,
   output logic             picked_up,
   input  logic             seq_end,
   output logic             play_valid,
   output logic [IDX_W-1:0] play_slot,
   output logic             play_loop,
   output logic             rel_valid,
   output logic [IDX_W-1:0] rel_slot,
   output logic             rel_loop
);
   localparam int unsigned NEED_W = $clog2(SLOT_COUNT);

   if (SLOT_COUNT != SLOTS) begin : g_bad_count
      $error("seqbuf_index_mgr: SLOT_COUNT must be 3");
   end
   if (IDX_W != NEED_W) begin : g_bad_width
      $error("seqbuf_index_mgr: IDX_W must equal clog2(SLOT_COUNT)");
   end

   slot_t rd_idx;
   slot_t lw_idx;
   slot_t pick;
   slot_t grant;
   play_t cur;
   play_t rel;

   seqbuf_write_picker u_pick (
      .rd_idx (rd_idx),
      .lw_idx (lw_idx),
      .pick   (pick)
   );

   seqbuf_producer_port u_prod (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_begin   (wr_begin),
      .wr_commit  (wr_commit),
      .pick       (pick),
      .grant_slot (grant),
      .busy       (wr_busy),
      .lw_idx     (lw_idx)
   );

   seqbuf_consumer_port u_cons (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_end    (seq_end),
      .lw_idx     (lw_idx),
      .rd_idx     (rd_idx),
      .play_valid (play_valid),
      .play_cur   (cur),
      .rel_valid  (rel_valid),
      .rel_buf    (rel)
   );

   assign wr_slot   = grant;
   assign picked_up = (rd_idx == lw_idx);
   assign play_slot = cur.slot;
   assign play_loop = cur.loop;
   assign rel_slot  = rel.slot;
   assign rel_loop  = rel.loop;
endmodule

// File: rtl/seqbuf_index_mgr_chk.sv
module seqbuf_index_mgr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_begin,
   input logic       wr_commit,
   input logic [1:0] wr_slot,
   input logic       wr_busy,
   input logic       seq_end,
   input logic       play_valid,
   input logic [1:0] play_slot,
   input logic       play_loop,
   input logic       rel_valid,
   input logic [1:0] rd_idx,
   input logic [1:0] lw_idx
);
   a_r2_grant_avoids_read: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |-> (wr_slot != rd_idx));

   a_r3_grant_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && $past(wr_busy)) |-> $stable(wr_slot));

   a_r4_commit_records: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && wr_commit) |=> (!wr_busy && lw_idx == $past(wr_slot)));

   a_r6_update_choice: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end && rd_idx != lw_idx) |=>
         (play_valid && !play_loop && play_slot == $past(lw_idx)));

   a_r7_loop_choice: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end && rd_idx == lw_idx) |=>
         (play_valid && play_loop && play_slot == $past(rd_idx)));

   a_r8_release_follows_play: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> play_valid);
endmodule

bind seqbuf_index_mgr seqbuf_index_mgr_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_begin   (wr_begin),
   .wr_commit  (wr_commit),
   .wr_slot    (wr_slot),
   .wr_busy    (wr_busy),
   .seq_end    (seq_end),
   .play_valid (play_valid),
   .play_slot  (play_slot),
   .play_loop  (play_loop),
   .rel_valid  (rel_valid),
   .rd_idx     (rd_idx),
   .lw_idx     (lw_idx)
);

// File: tb/seqbuf_index_mgr_bench.sv
module seqbuf_index_mgr_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_begin = 1'b0;
   logic       wr_commit = 1'b0;
   logic       seq_end = 1'b0;
   logic [1:0] wr_slot;
   logic       wr_busy;
   logic       picked_up;
   logic       play_valid;
   logic [1:0] play_slot;
   logic       play_loop;
   logic       rel_valid;
   logic [1:0] rel_slot;
   logic       rel_loop;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // model state
   int  m_rd = 0, m_lw = 0, m_slot = 0;
   bit  m_busy = 0, m_started = 0;
   int  m_cur_slot = 0;
   bit  m_cur_loop = 0;

   // expected item: {rel_valid, rel_slot[1:0], rel_loop, slot[1:0], loop}
   logic [6:0] exp_q[$];

   always #5 clk = ~clk;

   seqbuf_index_mgr u_seqbuf_index_mgr (
      .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_commit(wr_commit),
      .wr_slot(wr_slot), .wr_busy(wr_busy), .picked_up(picked_up),
      .seq_end(seq_end), .play_valid(play_valid), .play_slot(play_slot),
      .play_loop(play_loop), .rel_valid(rel_valid), .rel_slot(rel_slot),
      .rel_loop(rel_loop)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pick(input int rd, input int lw);
      int w = (rd + 1) % 3;
      return (w == lw) ? (rd + 2) % 3 : w;
   endfunction

   task automatic do_begin();
      wr_begin = 1'b1;
      if (!m_busy) begin
         m_slot = pick(m_rd, m_lw);
         m_busy = 1;
      end
      @(negedge clk);
      wr_begin = 1'b0;
      check("R2 R3 wr_slot", wr_slot, m_slot);
      check("R2 R3 wr_busy", wr_busy, m_busy);
   endtask

   task automatic do_step(input bit c, input bit e);
      wr_commit = c;
      seq_end   = e;
      if (e) begin
         int  ns;
         bit  nl;
         // R9: decision from indices before any commit in this cycle
         if (m_lw != m_rd) begin ns = m_lw; nl = 0; m_rd = m_lw; end
         else begin ns = m_rd; nl = 1; end
         exp_q.push_back({m_started, 2'(m_cur_slot), m_cur_loop, 2'(ns), nl});
         m_started = 1; m_cur_slot = ns; m_cur_loop = nl;
      end
      if (c && m_busy) begin
         m_lw = m_slot;
         m_busy = 0;
      end
      @(negedge clk);
      wr_commit = 1'b0;
      seq_end   = 1'b0;
      check("R4 wr_busy", wr_busy, m_busy);
      check("R5 picked_up", picked_up, (m_rd == m_lw));
   endtask

   // monitor: scoreboard pop on every playback pulse
   always @(negedge clk) begin
      if (rst_n && play_valid) begin
         if (exp_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R6 unexpected play_valid actual=1 expected=0");
         end else begin
            logic [6:0] e;
            e = exp_q.pop_front();
            check("R6 R7 play_slot", play_slot, e[2:1]);
            check("R6 R7 play_loop", play_loop, e[0]);
            check("R8 rel_valid", rel_valid, e[6]);
            if (e[6]) begin
               check("R8 rel_slot", rel_slot, e[5:4]);
               check("R8 rel_loop", rel_loop, e[3]);
            end
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 wr_busy", wr_busy, 0);
      check("R1 picked_up", picked_up, 1);
      check("R1 play_valid", play_valid, 0);
      check("R1 rel_valid", rel_valid, 0);

      // R4: commit while idle ignored
      do_step(1, 0);
      // R7/R8: first playback is loop of slot 0, nothing released
      do_step(0, 1);
      do_step(0, 0);
      // R2: grant slot 1, R3: second begin ignored
      do_begin();
      do_begin();
      do_step(1, 0);
      check("R5 picked_up low after commit", picked_up, 0);
      // R6: update of slot 1, loop 0 released
      do_step(0, 1);
      // producer commits twice before consumer catches up: forces (read+2)
      do_begin();
      do_step(1, 0);
      do_begin();
      check("R2 read+2 choice", wr_slot, 0);
      do_step(1, 0);
      do_step(0, 1);
      do_step(0, 1);
      do_step(0, 1);
      // R9: commit and seq_end same cycle
      do_begin();
      do_step(1, 1);
      do_step(0, 0);
      do_step(0, 1);
      do_step(0, 0);
      check("R6 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule